// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a processor bus and three down-counting timer channels. The host reaches it through an 8-bit data path, an active-low chip select, active-low read and write strobes and a two-bit address. Addresses 0, 1 and 2 reach the data port of the matching channel. Address 3 is the command port, where each byte is decoded as a programming word, a snapshot request or a multi-channel status query.

Each channel keeps its own access style: low byte only, high byte only, or low byte followed by high byte. The block assembles the initial count in that order and hands it to the channel with a one-cycle load strobe. Reads follow the same order. A read returns, in priority order, a pending status byte, then a pending count snapshot, then the live count from the channel. A snapshot holds still while the channel keeps counting. The channel logic sits outside this block. It supplies its live count, its output level and a pulse that marks when the initial count has moved into its counting element.

The bus is split into `d_in`, `d_out` and an enable `d_oe`, which drive an external bidirectional pad. Strobes are sampled on the rising clock edge. One cycle of strobe low is one access.

Top module: `timer_host_if`

## Requirements
- R1: Strobes have no effect while `cs_n` is high. A read of address 3 returns 0 with `d_oe` low. `d_oe` is high only for a read of addresses 0 to 2 while `cs_n` is low.
- R2: A command byte whose bits 7:6 are not 11 and whose bits 5:4 are not 00 programs the channel named by bits 7:6. Bits 5:4 set the access style (01 low only, 10 high only, 11 low then high). Bits 3:1 set the mode, with values 6 and 7 stored as 2 and 3. Bit 0 sets the BCD flag. `ch_mode` and `ch_bcd` show the stored values from the next cycle on.
- R3: In low-only style, a data write loads {00, byte}. In high-only style, a data write loads {byte, 00}. In both cases `ch_load` of that channel is high for exactly the one cycle after the write, and no two channels load in the same cycle.
- R4: In low-then-high style, the first data write after programming only holds the low byte and gives no load. The second write loads {second, first} with a load strobe.
- R5: A live read returns the low byte in low-only style and the high byte in high-only style. In low-then-high style, reads alternate low and high, starting with low after programming.
- R6: A command byte with bits 5:4 = 00 and bits 7:6 = 00, 01 or 10 captures that channel's live count. Reads return the captured bytes in the channel's byte order, whatever the live count does, until all of its bytes have been read. After that, reads return the live count again.
- R7: While a captured count or status byte has not been read, further capture requests for it are ignored and the held value is kept.
- R8: A command byte with bits 7:6 = 11 is a query. Bit 1, bit 2 and bit 3 select channels 0, 1 and 2. Bit 5 low captures the count and bit 4 low captures the status. The status byte is {output level, null-count, access style[1:0], mode[2:0], BCD} from bit 7 down.
- R9: When a status byte and a count are both pending, the first read returns the status and the following reads return the count bytes.
- R10: The null-count flag is set by programming and by a completed count load. It is cleared by the channel's `ch_xfer` pulse. A set and a clear in the same cycle leave it set.
- R11: After reset, no load strobe is active, every mode and BCD output is 0, and `d_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port select: 0 to 2 channel data, 3 command |
| d_in | input | 8 | Write data from the host |
| d_out | output | 8 | Read data to the host |
| d_oe | output | 1 | Drive enable for the external data pad |
| ch_mode | output | 9 | Stored mode, 3 bits per channel |
| ch_bcd | output | 3 | Stored BCD flag per channel |
| ch_load | output | 3 | One-cycle initial-count load strobe per channel |
| ch_count | output | 48 | Initial count, 16 bits per channel |
| ch_live | input | 48 | Present count from each channel |
| ch_out_lvl | input | 3 | Present output level of each channel |
| ch_xfer | input | 3 | Pulse: initial count moved into the counting element |

## Verification
Two things can land in the same clock on one channel: the host write that completes a count, which sets null-count, and the channel's transfer pulse, which clears it. The bench raises `ch_xfer` in the very cycle where the closing high byte is strobed. It then issues a status query and expects bit 6 still set. A second case of the same kind holds a snapshot pending while the live count changes and another capture is requested. The bench expects the old bytes back.

// File: rtl/timer_host_pkg.sv
`timescale 1ns/1ps
package timer_host_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic       out_lvl;
    logic       nul;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } status_t;

  // mode codes 6 and 7 alias 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction

endpackage

// File: rtl/thi_ctrl_decode.sv
`timescale 1ns/1ps
module thi_ctrl_decode
  import timer_host_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic            cw_we,
  input  logic [7:0]      cw,
  output logic [N_CH-1:0] prog,
  output logic [N_CH-1:0] lat_cnt,
  output logic [N_CH-1:0] lat_st,
  output acc_e            acc,
  output logic [2:0]      mode,
  output logic            bcd
);
  logic is_query;
  logic is_latch;

  always_comb begin
    is_query = (cw[7:6] == 2'b11);
    is_latch = (cw[5:4] == 2'b00);
    acc      = acc_e'(cw[5:4]);
    mode     = fold_mode(cw[3:1]);
    bcd      = cw[0];
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    logic hit;
    assign hit        = (cw[7:6] == 2'(i));
    assign prog[i]    = cw_we & ~is_query & hit & ~is_latch;
    assign lat_cnt[i] = cw_we & ((~is_query & hit & is_latch) |
                                 (is_query & ~cw[5] & cw[i+1]));
    assign lat_st[i]  = cw_we & is_query & ~cw[4] & cw[i+1];
  end

endmodule

// File: rtl/thi_chan_regs.sv
`timescale 1ns/1ps
module thi_chan_regs
  import timer_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog,
  input  acc_e            acc_in,
  input  logic [2:0]      mode_in,
  input  logic            bcd_in,
  input  logic            lat_cnt,
  input  logic            lat_st,
  input  logic            dwr,
  input  logic            drd,
  input  logic [DW-1:0]   din,
  input  logic [2*DW-1:0] live,
  input  logic            out_lvl,
  input  logic            xfer,
  output logic [2:0]      mode,
  output logic            bcd,
  output logic            load,
  output logic [2*DW-1:0] count,
  output logic [DW-1:0]   rd_byte
);
  localparam int CW = 2 * DW;

  acc_e          acc_q, acc_d;
  logic [2:0]    mode_q, mode_d;
  logic          bcd_q, bcd_d;
  logic          wptr_q, wptr_d;
  logic          rptr_q, rptr_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          load_q, load_d;
  logic          nul_q, nul_d;
  logic          clv_q, clv_d;
  logic [CW-1:0] clval_q, clval_d;
  logic          stv_q, stv_d;
  status_t       st_q, st_d;
  logic [CW-1:0] src;

  // next-state
  always_comb begin
    acc_d   = acc_q;
    mode_d  = mode_q;
    bcd_d   = bcd_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    lo_d    = lo_q;
    cnt_d   = cnt_q;
    load_d  = 1'b0;
    clv_d   = clv_q;
    clval_d = clval_q;
    stv_d   = stv_q;
    st_d    = st_q;

    if (prog) begin
      acc_d  = acc_in;
      mode_d = mode_in;
      bcd_d  = bcd_in;
      wptr_d = 1'b0;
      rptr_d = 1'b0;
      clv_d  = 1'b0;
      stv_d  = 1'b0;
    end else begin
      if (dwr) begin
        unique case (acc_q)
          ACC_LO: begin
            cnt_d  = {{DW{1'b0}}, din};
            load_d = 1'b1;
          end
          ACC_HI: begin
            cnt_d  = {din, {DW{1'b0}}};
            load_d = 1'b1;
          end
          ACC_LOHI: begin
            if (!wptr_q) begin
              lo_d   = din;
              wptr_d = 1'b1;
            end else begin
              cnt_d  = {din, lo_q};
              wptr_d = 1'b0;
              load_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (drd) begin
        if (stv_q) begin
          stv_d = 1'b0;
        end else begin
          if (acc_q == ACC_LOHI) rptr_d = ~rptr_q;
          if (clv_q && (acc_q != ACC_LOHI || rptr_q)) clv_d = 1'b0;
        end
      end
      if (lat_cnt && !clv_q) begin
        clv_d   = 1'b1;
        clval_d = live;
      end
      if (lat_st && !stv_q) begin
        stv_d = 1'b1;
        st_d  = '{out_lvl: out_lvl, nul: nul_q, acc: acc_q,
                  mode: mode_q, bcd: bcd_q};
      end
    end

    if (prog || load_d) nul_d = 1'b1;
    else if (xfer)      nul_d = 1'b0;
    else                nul_d = nul_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_LATCH;
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      wptr_q  <= 1'b0;
      rptr_q  <= 1'b0;
      lo_q    <= '0;
      cnt_q   <= '0;
      load_q  <= 1'b0;
      nul_q   <= 1'b0;
      clv_q   <= 1'b0;
      clval_q <= '0;
      stv_q   <= 1'b0;
      st_q    <= '0;
    end else begin
      acc_q   <= acc_d;
      mode_q  <= mode_d;
      bcd_q   <= bcd_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      lo_q    <= lo_d;
      if (load_d) cnt_q <= cnt_d;
      load_q  <= load_d;
      nul_q   <= nul_d;
      clv_q   <= clv_d;
      if (lat_cnt && !clv_q) clval_q <= clval_d;
      stv_q   <= stv_d;
      if (lat_st && !stv_q) st_q <= st_d;
    end
  end

  // read data
  always_comb begin
    src = clv_q ? clval_q : live;
    if (stv_q) begin
      rd_byte = DW'(st_q);
    end else begin
      unique case (acc_q)
        ACC_HI:   rd_byte = src[CW-1:DW];
        ACC_LOHI: rd_byte = rptr_q ? src[CW-1:DW] : src[DW-1:0];
        default:  rd_byte = src[DW-1:0];
      endcase
    end
  end

  assign mode  = mode_q;
  assign bcd   = bcd_q;
  assign load  = load_q;
  assign count = cnt_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clv_q && $past(clv_q)) |-> $stable(clval_q)); // R7

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (stv_q && drd && !lat_st && !prog) |=> !stv_q); // R9

  AST_NUL_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> nul_q); // R10

endmodule

// File: rtl/thi_rd_mux.sv
`timescale 1ns/1ps
module thi_rd_mux #(
  parameter int N_CH = 3,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input  logic [N_CH*DW-1:0] bytes,
  input  logic [AW-1:0]      addr,
  input  logic               en,
  output logic [DW-1:0]      dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (en && addr == AW'(i)) dout = bytes[i*DW +: DW];
    end
  end
endmodule

// File: rtl/timer_host_if.sv
`timescale 1ns/1ps
module timer_host_if
  import timer_host_pkg::*;
#(
  parameter int N_CH = 3,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      d_in,
  output logic [DW-1:0]      d_out,
  output logic               d_oe,
  output logic [3*N_CH-1:0]  ch_mode,
  output logic [N_CH-1:0]    ch_bcd,
  output logic [N_CH-1:0]    ch_load,
  output logic [2*DW*N_CH-1:0] ch_count,
  input  logic [2*DW*N_CH-1:0] ch_live,
  input  logic [N_CH-1:0]    ch_out_lvl,
  input  logic [N_CH-1:0]    ch_xfer
);
  localparam int CW = 2 * DW;
  localparam int AW = 2;
  localparam logic [AW-1:0] CMD_ADDR = AW'(3);

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic              wr_act, rd_act, cw_we, data_rd;
  logic [N_CH-1:0]   dwr, drd, prog, lat_cnt, lat_st;
  acc_e              dec_acc;
  logic [2:0]        dec_mode;
  logic              dec_bcd;
  logic [N_CH*DW-1:0] rd_bytes;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb begin
    wr_act  = ~cs_n & ~wr_n;
    rd_act  = ~cs_n & ~rd_n;
    cw_we   = wr_act & (addr == CMD_ADDR);
    data_rd = rd_act & (addr != CMD_ADDR);
    for (int i = 0; i < N_CH; i++) begin
      dwr[i] = wr_act & (addr == AW'(i));
      drd[i] = rd_act & (addr == AW'(i));
    end
  end

  thi_ctrl_decode #(.N_CH(N_CH)) u_dec (
    .cw_we   (cw_we),
    .cw      (d_in[7:0]),
    .prog    (prog),
    .lat_cnt (lat_cnt),
    .lat_st  (lat_st),
    .acc     (dec_acc),
    .mode    (dec_mode),
    .bcd     (dec_bcd)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    thi_chan_regs #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .prog    (prog[i]),
      .acc_in  (dec_acc),
      .mode_in (dec_mode),
      .bcd_in  (dec_bcd),
      .lat_cnt (lat_cnt[i]),
      .lat_st  (lat_st[i]),
      .dwr     (dwr[i]),
      .drd     (drd[i]),
      .din     (d_in),
      .live    (ch_live[i*CW +: CW]),
      .out_lvl (ch_out_lvl[i]),
      .xfer    (ch_xfer[i]),
      .mode    (ch_mode[i*3 +: 3]),
      .bcd     (ch_bcd[i]),
      .load    (ch_load[i]),
      .count   (ch_count[i*CW +: CW]),
      .rd_byte (rd_bytes[i*DW +: DW])
    );
  end

  thi_rd_mux #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_mux (
    .bytes (rd_bytes),
    .addr  (addr),
    .en    (data_rd),
    .dout  (d_out)
  );

  assign d_oe = data_rd;

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(ch_load)); // R3

  AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|ch_load) |-> $past(!cs_n && !wr_n && addr != CMD_ADDR)); // R4

  AST_CMD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_s_n)
    cw_we |=> (ch_load == '0)); // R2

endmodule

// File: tb/sim_timer_host_if.sv
`timescale 1ns/1ps
module sim_timer_host_if;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, rd_n, wr_n;
  logic [1:0]  addr;
  logic [7:0]  d_in;
  logic [7:0]  d_out;
  logic        d_oe;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd, ch_load, ch_out_lvl, ch_xfer;
  logic [47:0] ch_count, ch_live;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  timer_host_if u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load(ch_load),
    .ch_count(ch_count), .ch_live(ch_live),
    .ch_out_lvl(ch_out_lvl), .ch_xfer(ch_xfer)
  );

  // vector: op[31:30] addr[29:28] tag[27:24] val[23:8] exp[7:0]
  // op 0 = write val[7:0], 1 = read expect exp, 2 = set live of channel
  localparam logic [31:0] VEC [29] = '{
    32'h86_1234_00, // R6 live ch0
    32'h32_0034_00, // R2 ch0 lo/hi mode2
    32'h45_0000_34, // R5
    32'h45_0000_12, // R5
    32'h36_0000_00, // R6 capture ch0
    32'h86_ABCD_00,
    32'h46_0000_34, // R6
    32'h87_5555_00,
    32'h37_0000_00, // R7 second capture ignored
    32'h47_0000_12, // R7
    32'h86_5A3C_00,
    32'h46_0000_3C, // R6 live again
    32'h46_0000_5A, // R6
    32'h32_0052_00, // R2 ch1 low only mode1
    32'h96_77EE_00,
    32'h55_0000_EE, // R5
    32'h55_0000_EE, // R5
    32'h32_00A7_00, // R2 ch2 high only mode3 bcd
    32'hA6_9F01_00,
    32'h65_0000_9F, // R5
    32'h38_00C2_00, // R8 query ch0 count+status
    32'h49_0000_F4, // R9 status first
    32'h49_0000_3C, // R9
    32'h49_0000_5A, // R9
    32'h38_00EC_00, // R8 status ch1 and ch2
    32'h58_0000_52, // R8
    32'h59_0000_EE, // R9 back to live
    32'h68_0000_E7, // R8
    32'h69_0000_9F  // R9
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = a; d_in = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q, output logic oe);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    #1 q = d_out; oe = d_oe;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic       oe;
    rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; d_in = 0;
    ch_live = '0; ch_out_lvl = 3'b101; ch_xfer = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 load", {13'd0, ch_load}, 16'h0);
    chk("R11 mode", {7'd0, ch_mode}, 16'h0);
    chk("R11 bcd", {13'd0, ch_bcd}, 16'h0);
    chk("R11 oe", {15'd0, d_oe}, 16'h0);

    // table walk
    foreach (VEC[k]) begin
      logic [1:0] op, a;
      logic [3:0] tg;
      op = VEC[k][31:30]; a = VEC[k][29:28]; tg = VEC[k][27:24];
      case (op)
        2'd0: wr(a, VEC[k][15:8]);
        2'd1: begin
          rd(a, q, oe);
          chk($sformatf("R%0d vec%0d", tg, k), {8'd0, q}, {8'd0, VEC[k][7:0]});
        end
        default: begin
          @(negedge clk);
          ch_live[a*16 +: 16] = VEC[k][23:8];
        end
      endcase
    end

    // R2 control word outputs
    chk("R2 ch0 mode", {13'd0, ch_mode[2:0]}, 16'd2);
    chk("R2 ch2 bcd", {15'd0, ch_bcd[2]}, 16'd1);

    // R3 low only
    wr(3, 8'h10);
    wr(0, 8'h5A);
    chk("R3 lo load", {13'd0, ch_load}, 16'h1);
    chk("R3 lo count", ch_count[15:0], 16'h005A);
    @(negedge clk);
    chk("R3 pulse width", {13'd0, ch_load}, 16'h0);

    // R3 high only
    wr(3, 8'h60);
    wr(1, 8'h3C);
    chk("R3 hi load", {13'd0, ch_load}, 16'h2);
    chk("R3 hi count", ch_count[31:16], 16'h3C00);

    // R4 low then high
    wr(3, 8'hB0);
    wr(2, 8'h11);
    chk("R4 no load after first", {13'd0, ch_load}, 16'h0);
    wr(2, 8'h22);
    chk("R4 load", {13'd0, ch_load}, 16'h4);
    chk("R4 count", ch_count[47:32], 16'h2211);

    // R1 write without chip select ignored
    @(negedge clk);
    cs_n = 1; wr_n = 0; addr = 2; d_in = 8'h99;
    @(negedge clk);
    wr_n = 1;
    chk("R1 no load", {13'd0, ch_load}, 16'h0);
    wr(2, 8'h33);
    wr(2, 8'h44);
    chk("R1 order intact", ch_count[47:32], 16'h4433);

    // R10 null-count set, then cleared by transfer
    wr(3, 8'hE8);
    rd(2, q, oe);
    chk("R10 nul set", {8'd0, q}, 16'h00F0);
    @(negedge clk); ch_xfer = 3'b100;
    @(negedge clk); ch_xfer = 3'b000;
    wr(3, 8'hE8);
    rd(2, q, oe);
    chk("R10 nul cleared", {8'd0, q}, 16'h00B0);

    // R10 set and clear in the same cycle
    wr(2, 8'h01);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = 2; d_in = 8'h02; ch_xfer = 3'b100;
    @(negedge clk);
    cs_n = 1; wr_n = 1; ch_xfer = 3'b000;
    chk("R10 same-cycle count", ch_count[47:32], 16'h0201);
    wr(3, 8'hE8);
    rd(2, q, oe);
    chk("R10 set wins", {8'd0, q}, 16'h00F0);

    // R2 mode fold and bcd, status layout
    wr(3, 8'h11);
    chk("R2 bcd set", {15'd0, ch_bcd[0]}, 16'h1);
    wr(3, 8'h5C);
    chk("R2 mode 6 folds to 2", {13'd0, ch_mode[5:3]}, 16'd2);
    wr(3, 8'hE2);
    rd(0, q, oe);
    chk("R8 status layout", {8'd0, q}, 16'h00D1);

    // R7 status capture ignored while pending; R9 then live
    ch_out_lvl[0] = 1'b0;
    wr(3, 8'hE2);
    ch_out_lvl[0] = 1'b1;
    wr(3, 8'hE2);
    rd(0, q, oe);
    chk("R7 held status", {8'd0, q}, 16'h0051);
    rd(0, q, oe);
    chk("R9 live after status", {8'd0, q}, 16'h003C);
    chk("R1 oe on data read", {15'd0, oe}, 16'h1);

    // R1 command address read
    rd(3, q, oe);
    chk("R1 cmd read data", {8'd0, q}, 16'h0);
    chk("R1 cmd read oe", {15'd0, oe}, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule